// File: doc/BRIEF.md
# SAR conversion timing sequencer

This block is the digital controller for a single conversion of a 10-bit successive-approximation converter. A start strobe captures a command that holds a channel number, a bypass flag and a two-bit sample-length code. The block then steps through three phases. The first is a buffered sample phase. The second is a direct sample phase. The third is a bit-by-bit resolution phase. Every phase is timed in ticks of a conversion-clock enable.

The block drives four things to the analog side: the channel select, the buffer-amplifier enable, the sample switch and the trial code for the DAC. On every resolution tick it reads one comparator decision back. When the last bit is decided, the block writes the code into a result register and pulses end-of-conversion. An end-of-sample pulse marks the move from sampling into resolution. A stop input can cancel a conversion at any point.

Top module: `sar_seq`

## Requirements
- R1: A synchronous reset clears the outputs. After reset, `busy`, `amp_en`, `samp_sw`, `eos` and `eoc` are low, and `dac_code`, `result` and `chan_sel` are zero.
- R2: A `start` strobe seen while idle captures `cmd_chan`, `cmd_byp` and `cmd_ist`. `chan_sel` then shows the captured channel for the whole conversion. A `start` strobe that arrives while `busy` is high has no effect.
- R3: The first phase lasts exactly 2 ticks. `amp_en` is high during that phase only, and only when the captured bypass bit is 0. When the bypass bit is 1, `amp_en` stays low for the whole conversion.
- R4: The second phase lasts 2, 4, 8 or 16 ticks, for `cmd_ist` values 0, 1, 2 and 3. `samp_sw` is high for the first and second phases and low at all other times.
- R5: The resolution phase takes 10 ticks and decides one bit per tick, most significant bit first. Each trial bit is set to 1 in `dac_code`. It is cleared on its tick if `cmp_hi` is 1, meaning the DAC voltage is above the input. `dac_code` is 0 outside resolution.
- R6: `eos` is high for exactly one clock cycle. That cycle follows the clock edge on which the second phase ends.
- R7: `eoc` is high for exactly one clock cycle. In that same cycle `result` first shows the new 10-bit code. `result` changes at no other time except reset.
- R8: `stop` returns the block to idle on the next edge from any state. `result` keeps its value and no `eoc` is produced. If `stop` and `start` are both high while idle, no conversion starts.
- R9: Phase timing advances only on clock edges where `tick` is high. Cycles without `tick` lengthen a conversion and do not change its result.
- R10: A conversion needs 12 plus the second-phase length in ticks, counted from the start edge to the edge that raises `eoc`. The shortest case is 14 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Conversion-clock enable |
| start | input | 1 | Start strobe, taken only while idle |
| stop | input | 1 | Abort, returns the block to idle |
| cmd_chan | input | 6 | Channel number in the command |
| cmd_byp | input | 1 | Buffer-amplifier bypass bit in the command |
| cmd_ist | input | 2 | Second-phase length code (2 << code ticks) |
| cmp_hi | input | 1 | Comparator: DAC voltage is above the input |
| chan_sel | output | 6 | Channel select for the analog multiplexer |
| amp_en | output | 1 | Buffer-amplifier enable |
| samp_sw | output | 1 | Sample switch closed |
| dac_code | output | 10 | Trial code sent to the DAC |
| result | output | 10 | Last completed conversion result |
| eos | output | 1 | End-of-sample pulse |
| eoc | output | 1 | End-of-conversion pulse |
| busy | output | 1 | A conversion is in progress |

## Verification
Several properties are checked on every cycle by the assertions:
- phase and counter state hold still on cycles without a tick;
- a stop always lands in idle;
- `eoc` lasts a single cycle and is the only cycle in which `result` may change;
- `eos` occurs only on entry to resolution;
- `amp_en` is never high outside sampling;
- the channel select is stable while busy;
- the bits below the current trial position are zero during resolution.

Other behaviours need the bench scenarios, which compare the design with an elapsed-tick reference model. These are the exact phase lengths for each sample code, the converged code for given input levels, the stretch under a sparse tick, and what an abort or a repeated start does to the result and the channel.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BUF   = 2'd1,
        PH_DIRECT = 2'd2,
        PH_RESOLVE = 2'd3
    } phase_e;
endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int BUF_TICKS  = 2,
    parameter int DIR_BASE   = 2,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [1:0]       ist,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             go_res,
    output logic             res_step,
    output logic             res_last
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: PH_IDLE, cnt: '0};

    ctl_t st_d, st_q;
    logic [CNT_W-1:0] dir_last;

    assign dir_last = CNT_W'((DIR_BASE << ist) - 1);
    assign go_res   = (st_q.ph == PH_DIRECT) && tick && !stop && (st_q.cnt == dir_last);
    assign res_step = (st_q.ph == PH_RESOLVE) && tick && !stop;
    assign res_last = (st_q.cnt == CNT_W'(RES_BITS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_BUF;
                    st_d.cnt = '0;
                end
            end
            PH_BUF: begin
                if (tick) begin
                    if (st_q.cnt == CNT_W'(BUF_TICKS - 1)) begin
                        st_d.ph  = PH_DIRECT;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DIRECT: begin
                if (tick) begin
                    if (st_q.cnt == dir_last) begin
                        st_d.ph  = PH_RESOLVE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_RESOLVE: begin
                if (tick) begin
                    if (res_last) begin
                        st_d.ph  = PH_IDLE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d = CTL_RST;
        endcase
        if (stop) st_d = CTL_RST;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CTL_RST;
        else     st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;

    // R9
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph != PH_IDLE && !tick && !stop) |=> ($stable(st_q.cnt) && $stable(st_q.ph)));

    // R8
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (st_q.ph == PH_IDLE));
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 4,
    localparam int IDX_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                load,
    input  logic                step,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] decided
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] code_d, code_q;
    logic [IDX_W-1:0]    idx;

    assign idx = IDX_W'(RES_BITS - 1) - cnt[IDX_W-1:0];

    always_comb begin
        decided = code_q;
        if (cmp_hi) decided[idx] = 1'b0;
        if (idx != '0) decided[idx - 1'b1] = 1'b1;
    end

    always_comb begin
        code_d = code_q;
        if (clr)       code_d = '0;
        else if (load) code_d = MSB_ONLY;
        else if (step) code_d = decided;
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_d;
    end

    assign code = code_q;

    // R5
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ((code_q & ~({RES_BITS{1'b1}} << idx)) == '0));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS  = 10,
    parameter int CH_W      = 6,
    parameter int BUF_TICKS = 2,
    parameter int DIR_BASE  = 2,
    localparam int MAX_CNT  = (DIR_BASE << 3) > RES_BITS ?
                              ((DIR_BASE << 3) > BUF_TICKS ? (DIR_BASE << 3) : BUF_TICKS) :
                              (RES_BITS > BUF_TICKS ? RES_BITS : BUF_TICKS),
    localparam int CNT_W    = $clog2(MAX_CNT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic                stop,
    input  logic [CH_W-1:0]     cmd_chan,
    input  logic                cmd_byp,
    input  logic [1:0]          cmd_ist,
    input  logic                cmp_hi,
    output logic [CH_W-1:0]     chan_sel,
    output logic                amp_en,
    output logic                samp_sw,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                eos,
    output logic                eoc,
    output logic                busy
);
    typedef struct packed {
        logic [CH_W-1:0]     chan;
        logic                byp;
        logic [1:0]          ist;
        logic [RES_BITS-1:0] res;
        logic                eos;
        logic                eoc;
    } top_t;

    top_t st_d, st_q;

    phase_e              phase;
    logic [CNT_W-1:0]    cnt;
    logic                go_res, res_step, res_last;
    logic [RES_BITS-1:0] decided;

    sar_phase_ctl #(
        .RES_BITS (RES_BITS),
        .BUF_TICKS(BUF_TICKS),
        .DIR_BASE (DIR_BASE),
        .CNT_W    (CNT_W)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start),
        .stop    (stop),
        .ist     (st_q.ist),
        .phase   (phase),
        .cnt     (cnt),
        .go_res  (go_res),
        .res_step(res_step),
        .res_last(res_last)
    );

    sar_bit_reg #(
        .RES_BITS(RES_BITS),
        .CNT_W   (CNT_W)
    ) u_bits (
        .clk    (clk),
        .rst    (rst),
        .clr    (stop || (res_step && res_last)),
        .load   (go_res),
        .step   (res_step),
        .cnt    (cnt),
        .cmp_hi (cmp_hi),
        .code   (dac_code),
        .decided(decided)
    );

    always_comb begin
        st_d     = st_q;
        st_d.eos = 1'b0;
        st_d.eoc = 1'b0;
        if (phase == PH_IDLE && start && !stop) begin
            st_d.chan = cmd_chan;
            st_d.byp  = cmd_byp;
            st_d.ist  = cmd_ist;
        end
        if (go_res) st_d.eos = 1'b1;
        if (res_step && res_last) begin
            st_d.res = decided;
            st_d.eoc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign chan_sel = st_q.chan;
    assign amp_en   = (phase == PH_BUF) && !st_q.byp;
    assign samp_sw  = (phase == PH_BUF) || (phase == PH_DIRECT);
    assign result   = st_q.res;
    assign eos      = st_q.eos;
    assign eoc      = st_q.eoc;
    assign busy     = (phase != PH_IDLE);

    // R7
    eoc_single_chk: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    // R7
    result_only_on_eoc_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> eoc);

    // R6
    eos_enters_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        eos |-> (phase == PH_RESOLVE || $past(stop)));

    // R3
    amp_within_sample_chk: assert property (@(posedge clk) disable iff (rst)
        amp_en |-> samp_sw);

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(chan_sel));
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [5:0] cmd_chan = '0;
    logic       cmd_byp = 1'b0;
    logic [1:0] cmd_ist = '0;
    logic       cmp_hi;
    logic [5:0] chan_sel;
    logic       amp_en, samp_sw, eos, eoc, busy;
    logic [9:0] dac_code, result;

    int vin = 0;
    int tick_mode = 0;
    int tdiv = 0;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_en = 0;

    assign cmp_hi = (int'(dac_code) > vin);

    sar_seq u0 (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .stop(stop),
        .cmd_chan(cmd_chan), .cmd_byp(cmd_byp), .cmd_ist(cmd_ist), .cmp_hi(cmp_hi),
        .chan_sel(chan_sel), .amp_en(amp_en), .samp_sw(samp_sw), .dac_code(dac_code),
        .result(result), .eos(eos), .eoc(eoc), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // reference model: elapsed ticks since start
    bit m_busy = 0, m_byp = 0, m_eos = 0, m_eoc = 0;
    int m_t = 0, m_ist = 0, m_chan = 0, m_code = 0, m_res = 0;

    always @(posedge clk) begin
        int span;
        bit cmp_m;
        cmp_m = (m_code > vin);
        if (rst) begin
            m_busy = 0; m_byp = 0; m_eos = 0; m_eoc = 0;
            m_t = 0; m_ist = 0; m_chan = 0; m_code = 0; m_res = 0;
        end else begin
            m_eos = 0; m_eoc = 0;
            if (stop) begin
                m_busy = 0; m_code = 0;
            end else if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_t = 0;
                    m_chan = int'(cmd_chan); m_byp = cmd_byp; m_ist = int'(cmd_ist);
                end
            end else if (tick) begin
                span = 2 + (2 << m_ist);
                if (m_t >= span) begin
                    int k;
                    k = m_t - span;
                    if (cmp_m) m_code = m_code & ~(1 << (9 - k));
                    if (k == 9) begin
                        m_res = m_code; m_eoc = 1; m_busy = 0; m_code = 0;
                    end else begin
                        m_code = m_code | (1 << (8 - k));
                    end
                end
                m_t++;
                if (m_busy && m_t == span) begin
                    m_code = 512; m_eos = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        int span;
        cyc++;
        if (tick_mode == 0) tick <= 1'b1;
        else begin
            tdiv = (tdiv + 1) % 3;
            tick <= (tdiv == 0);
        end
        if (cmp_en) begin
            span = 2 + (2 << m_ist);
            chk("R1/R2 busy",     int'(busy),     int'(m_busy));
            chk("R2 chan_sel",    int'(chan_sel), m_chan);
            chk("R3 amp_en",      int'(amp_en),   int'(m_busy && m_t < 2 && !m_byp));
            chk("R4 samp_sw",     int'(samp_sw),  int'(m_busy && m_t < span));
            chk("R5 dac_code",    int'(dac_code), m_code);
            chk("R6 eos",         int'(eos),      int'(m_eos));
            chk("R7 eoc",         int'(eoc),      int'(m_eoc));
            chk("R7 result",      int'(result),   m_res);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic convert(input int ch, input bit byp, input int ist, input int v,
                           output int ticks, output int eos_cnt);
        vin = v;
        @(negedge clk);
        cmd_chan = 6'(ch); cmd_byp = byp; cmd_ist = 2'(ist); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ticks = 0; eos_cnt = 0;
        for (int i = 0; i < 2000; i++) begin
            if (eoc) break;
            @(posedge clk);
            if (tick) ticks++;
            @(negedge clk);
            if (eos) eos_cnt++;
        end
    endtask

    initial begin
        int tk, ne;
        int prev;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 eoc", int'(eoc), 0);
        rst = 1'b0;
        @(negedge clk);
        cmp_en = 1;

        // R4 R10 R5 R7: every sample code, with and without bypass
        for (int ist = 0; ist < 4; ist++) begin
            int lvl;
            lvl = (ist == 0) ? 0 : (ist == 1) ? 1023 : (ist == 2) ? 682 : 345;
            convert(ist + 9, ist[0], ist, lvl, tk, ne);
            chk("R10 conversion ticks", tk, 12 + (2 << ist));
            chk("R5 converged code", int'(result), lvl);
            chk("R6 eos count", ne, 1);
            chk("R3 amp_en after", int'(amp_en), 0);
        end

        // R9: sparse tick
        tick_mode = 1;
        convert(33, 1'b0, 1, 513, tk, ne);
        chk("R9 sparse tick result", int'(result), 513);
        chk("R9 sparse tick count", tk, 16);
        tick_mode = 0;

        // R2: start while busy is ignored
        vin = 200;
        @(negedge clk);
        cmd_chan = 6'd5; cmd_byp = 1'b0; cmd_ist = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        cmd_chan = 6'd60; cmd_ist = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 chan kept", int'(chan_sel), 5);
        for (int i = 0; i < 100; i++) begin
            if (eoc) break;
            @(negedge clk);
        end
        chk("R2 result of first cmd", int'(result), 200);
        repeat (2) @(negedge clk);
        chk("R2 idle after", int'(busy), 0);

        // R8: stop mid-resolution
        prev = int'(result);
        vin = 777;
        @(negedge clk);
        cmd_chan = 6'd7; cmd_ist = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R8 aborted busy", int'(busy), 0);
        chk("R8 dac cleared", int'(dac_code), 0);
        repeat (20) @(negedge clk);
        chk("R8 result kept", int'(result), prev);

        // R8: stop and start together while idle
        cmd_chan = 6'd3; start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R8 stop beats start", int'(busy), 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule